// File: doc/BRIEF.md
# Three-State Sequence Counter with Hold/Flip Storage Cells

This block is a synchronous counter that walks the repeating cycle 00, 11, 10 and back to 00. It moves one step only on a clock edge where the advance input is high, and keeps its value on every other edge. It is meant for control paths that need a short non-binary cycle. It exposes the control pair of each storage cell so that the cell drive can be checked from outside.

Each count bit is held in a small storage cell with two control inputs, M and N. The pair M=1,N=0 makes the cell keep its bit. The pair M=0,N=1 makes the cell invert its bit. A combinational next-state stage looks at the present count and the advance input. For each bit it then selects keep or invert. It never produces the pairs 00 or 11; a cell that did receive either of them would keep its bit. The code 01 is not part of the cycle. If the counter ever holds 01, the next advance moves it to 00. The reset value is a parameter (default 00) so that the recovery path can be exercised.

Top module: `tri_seq_counter`

## Requirements
- R1: On a rising edge with `rst` low and `adv` high, `count` moves 00→11, 11→10 and 10→00. The new value is visible right after that same edge.
- R2: On a rising edge with `rst` low and `adv` low, `count` keeps its value.
- R3: `cell_m[i]`/`cell_n[i]` are the control pair of count bit i and follow the present `count` and `adv` combinationally. A bit that keeps its value on the coming edge is driven with M=1, N=0. This includes every bit while `adv` is low.
- R4: A bit that changes value on the coming edge (0→1 or 1→0) is driven with M=0, N=1.
- R5: No bit is ever driven with the pair M=0,N=0 or the pair M=1,N=1.
- R6: A rising edge with `rst` high loads `count` with `RESET_CODE` (default 00), whatever `adv` is.
- R7: The unused code 01 moves to 00 on the next rising edge with `adv` high, and keeps its value while `adv` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance strobe; the count steps on an edge where it is high |
| count | output | 2 | Present count, bit 1 is the left digit of the cycle codes |
| cell_m | output | 2 | M control input of each bit's cell |
| cell_n | output | 2 | N control input of each bit's cell |

## Verification
A corrupted cell bit or wrong next-state decode shows up at the ports the moment it happens, because the M/N pairs are combinational from the stored count. A wrong pair is visible before the edge that would use it. A wrong count is visible one edge after the bad update. The scoreboard compares both at every cycle, so an error appears within one clock period. The unused code is only reachable through the reset value, so a second instance with reset code 01 exercises the recovery path.

// File: rtl/tri_seq_pkg.sv
package tri_seq_pkg;

   localparam int CODE_W = 2;

   typedef logic [CODE_W-1:0] code_t;

   typedef struct packed {
      logic m;
      logic n;
   } cell_ctl_t;

   localparam cell_ctl_t CTL_KEEP = '{m: 1'b1, n: 1'b0};
   localparam cell_ctl_t CTL_FLIP = '{m: 1'b0, n: 1'b1};

   localparam code_t C_START = 2'b00;
   localparam code_t C_SECOND = 2'b11;
   localparam code_t C_THIRD = 2'b10;
   localparam code_t C_SPARE = 2'b01;

   // Successor of a code in the cycle; the spare code folds to the start.
   function automatic code_t step_code(input code_t cur);
      unique case (cur)
         C_START:  return C_SECOND;
         C_SECOND: return C_THIRD;
         C_THIRD:  return C_START;
         default:  return C_START;
      endcase
   endfunction

endpackage

// File: rtl/tri_seq_cell.sv
// One storage bit steered by an M/N pair: keep on 10, invert on 01,
// keep on the two pairs the driver never produces.
module tri_seq_cell
   import tri_seq_pkg::*;
#(
   parameter bit RST_VAL = 1'b0
) (
   input  logic      clk,
   input  logic      rst,
   input  cell_ctl_t ctl,
   output logic      q
);

   logic q_nxt;

   always_comb begin
      unique case ({ctl.m, ctl.n})
         2'b01:   q_nxt = ~q;
         default: q_nxt = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= q_nxt;
   end

endmodule

// File: rtl/tri_seq_drive.sv
// Next-state stage: picks keep or invert for every bit.
module tri_seq_drive
   import tri_seq_pkg::*;
#(
   parameter int NBITS = CODE_W
) (
   input  logic [NBITS-1:0] cur,
   input  logic             adv,
   output cell_ctl_t        ctl [NBITS]
);

   code_t target;

   always_comb begin
      target = adv ? step_code(cur) : cur;
   end

   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      always_comb begin
         ctl[b] = (target[b] != cur[b]) ? CTL_FLIP : CTL_KEEP;
      end
   end

endmodule

// File: rtl/tri_seq_counter.sv
module tri_seq_counter
   import tri_seq_pkg::*;
#(
   parameter int         NBITS      = 2,
   parameter logic [1:0] RESET_CODE = 2'b00
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [NBITS-1:0] count,
   output logic [NBITS-1:0] cell_m,
   output logic [NBITS-1:0] cell_n
);

   if (NBITS != CODE_W) begin : g_bad_width
      $error("tri_seq_counter: NBITS must equal %0d", CODE_W);
   end

   cell_ctl_t ctl [NBITS];

   tri_seq_drive #(.NBITS(NBITS)) u_drive (
      .cur (count),
      .adv (adv),
      .ctl (ctl)
   );

   for (genvar b = 0; b < NBITS; b++) begin : g_cell
      tri_seq_cell #(.RST_VAL(RESET_CODE[b])) u_cell (
         .clk (clk),
         .rst (rst),
         .ctl (ctl[b]),
         .q   (count[b])
      );
      assign cell_m[b] = ctl[b].m;
      assign cell_n[b] = ctl[b].n;
   end

endmodule

// File: rtl/tri_seq_counter_chk.sv
module tri_seq_counter_chk #(
   parameter int         NBITS      = 2,
   parameter logic [1:0] RESET_CODE = 2'b00
) (
   input logic             clk,
   input logic             rst,
   input logic             adv,
   input logic [NBITS-1:0] count,
   input logic [NBITS-1:0] cell_m,
   input logic [NBITS-1:0] cell_n
);

   a_r1_from_start: assert property (@(posedge clk) disable iff (rst)
      adv && count == 2'b00 |=> count == 2'b11);
   a_r1_from_second: assert property (@(posedge clk) disable iff (rst)
      adv && count == 2'b11 |=> count == 2'b10);
   a_r1_from_third: assert property (@(posedge clk) disable iff (rst)
      adv && count == 2'b10 |=> count == 2'b00);
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(count));
   a_r5_legal_pairs: assert property (@(posedge clk) disable iff (rst)
      (cell_m ^ cell_n) == {NBITS{1'b1}});
   a_r6_reset_load: assert property (@(posedge clk)
      rst |=> count == RESET_CODE);
   a_r7_spare_exit: assert property (@(posedge clk) disable iff (rst)
      adv && count == 2'b01 |=> count == 2'b00);

   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      a_r3_keep_pair: assert property (@(posedge clk) disable iff (rst)
         cell_m[b] && !cell_n[b] |=> count[b] == $past(count[b]));
      a_r4_flip_pair: assert property (@(posedge clk) disable iff (rst)
         !cell_m[b] && cell_n[b] |=> count[b] != $past(count[b]));
   end

endmodule

bind tri_seq_counter tri_seq_counter_chk #(.NBITS(NBITS), .RESET_CODE(RESET_CODE)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .adv    (adv),
   .count  (count),
   .cell_m (cell_m),
   .cell_n (cell_n)
);

// File: tb/tb_tri_seq_counter.sv
module tb_tri_seq_counter;

   typedef struct {
      logic [1:0] cnt;
      logic [1:0] m;
      logic [1:0] n;
      string      tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic adv = 1'b0;
   logic [1:0] count, cell_m, cell_n;

   logic rst_o = 1'b1;
   logic adv_o = 1'b0;
   logic [1:0] count_o, cell_m_o, cell_n_o;

   int checks = 0;
   int fails = 0;
   item_t sb[$];
   logic [1:0] model;
   string last_tag;
   bit driving_done = 1'b0;

   always #2 clk = ~clk;

   tri_seq_counter dut (
      .clk(clk), .rst(rst), .adv(adv),
      .count(count), .cell_m(cell_m), .cell_n(cell_n));

   tri_seq_counter #(.RESET_CODE(2'b01)) dut_odd (
      .clk(clk), .rst(rst_o), .adv(adv_o),
      .count(count_o), .cell_m(cell_m_o), .cell_n(cell_n_o));

   function automatic logic [1:0] succ(input logic [1:0] c);
      case (c)
         2'b00:   return 2'b11;
         2'b11:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and queues what the ports
   // must show before the coming edge.
   task automatic apply(input logic r, input logic a);
      item_t it;
      logic [1:0] tgt;
      @(posedge clk);
      #1;
      rst = r;
      adv = a;
      tgt = a ? succ(model) : model;
      it.cnt = model;
      it.m = ~(tgt ^ model);
      it.n = tgt ^ model;
      it.tag = last_tag;
      sb.push_back(it);
      model = r ? 2'b00 : tgt;
      last_tag = r ? "R6" : (a ? "R1" : "R2");
   endtask

   // Monitor: compares ports with the queue head at mid-cycle.
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() != 0) begin
            item_t it;
            it = sb.pop_front();
            check({it.tag, " count"}, count, it.cnt);
            check("R3/R4/R5 cell_m", cell_m, it.m);
            check("R3/R4/R5 cell_n", cell_n, it.n);
         end
      end
   end

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      model = 2'b00;
      last_tag = "R6";
      repeat (2) @(posedge clk);
      apply(0, 0);
      apply(0, 0);
      for (int k = 0; k < 7; k++) apply(0, 1);
      for (int k = 0; k < 6; k++) apply(0, k[0]);
      apply(0, 1);
      apply(1, 1);
      apply(0, 0);
      apply(0, 1);
      apply(1, 0);
      for (int k = 0; k < 9; k++) apply(0, (k % 3) != 0);
      apply(0, 0);
      wait (sb.size() == 0);
      @(negedge clk);

      // Spare-code recovery on the instance that resets into 01.
      @(posedge clk); #1; rst_o = 1'b0;
      @(negedge clk);
      check("R6 odd reset count", count_o, 2'b01);
      repeat (2) @(negedge clk);
      check("R7 odd hold count", count_o, 2'b01);
      check("R3 odd idle cell_m", cell_m_o, 2'b11);
      check("R3 odd idle cell_n", cell_n_o, 2'b00);
      @(posedge clk); #1; adv_o = 1'b1;
      @(negedge clk);
      check("R4/R7 odd cell_m", cell_m_o, 2'b10);
      check("R4/R7 odd cell_n", cell_n_o, 2'b01);
      @(posedge clk); #1; adv_o = 1'b0;
      @(negedge clk);
      check("R7 odd exit count", count_o, 2'b00);
      @(posedge clk); #1; adv_o = 1'b1;
      @(posedge clk); #1; adv_o = 1'b0;
      @(negedge clk);
      check("R1 odd resume count", count_o, 2'b11);

      driving_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule